// File: doc/BRIEF.md
# Opcode exception classifier

This block looks at one fetched 16-bit instruction word, together with the processor's current supervisor-mode bit. It decides whether that word must enter exception processing instead of executing. There are three causes. The first is a small set of reserved trap patterns that are always illegal. The second is the two opcode lines kept free for software emulation, each with its own vector. The third is the group of privileged instructions when they are attempted from user mode. Every other word passes with no exception flagged.

The result is a valid flag and an 8-bit vector number, chosen by a fixed priority so that at most one cause is ever reported. A parameter selects whether the result leaves through a register or comes straight from the decode logic. A qualifying input marks the cycles in which the word on the opcode input is meaningful. The block does not decode operands and does not sequence exception entry.

Top module: `opc_exc_classifier`

## Requirements
- R1: The words 0x4AFA, 0x4AFB and 0x4AFC are flagged in either mode with vector 4.
- R2: A word whose bits 15:12 are 1010 is flagged in either mode with vector 10.
- R3: A word whose bits 15:12 are 1111 is flagged in either mode with vector 11.
- R4: With supervisor low, these privileged words are flagged with vector 8:
  - 0x007C, 0x027C and 0x0A7C (OR, AND and EOR immediate to the status register);
  - 0x40C0-0x40FF (move from the status register);
  - 0x46C0-0x46FF (move to the status register);
  - 0x4E60-0x4E6F (user stack pointer move);
  - 0x4E70 (reset), 0x4E72 (stop) and 0x4E73 (return from exception);
  - 0x4E7A-0x4E7B (control register move);
  - 0x0E00-0x0EBF (address-space move: high byte 0x0E with bits 7:6 not 11).
- R5: With supervisor high, the words listed in R4 raise no exception: exc_valid is 0 and exc_vector is 0.
- R6: Every word not covered by R1 to R4 gives exc_valid 0 and exc_vector 0.
- R7: While decode_valid is low, exc_valid is 0 and exc_vector is 0, whatever the opcode and mode.
- R8: With the default registered output, the result for the inputs at one rising clock edge appears after that edge. An active-low reset clears exc_valid and exc_vector to 0.
- R9: Whenever exc_valid is high, exc_vector is exactly one of 4, 8, 10 or 11, chosen with the emulation lines first, then the fixed trap patterns, then the privilege check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| decode_valid | input | 1 | Qualifies opcode for this cycle |
| opcode | input | 16 | Fetched instruction word |
| supervisor | input | 1 | Current mode: 1 supervisor, 0 user |
| exc_valid | output | 1 | An exception must be taken for this word |
| exc_vector | output | 8 | Vector number; 0 when exc_valid is low |

## Verification
The bench walks every one of the 65536 words in both modes. This catches a privilege pattern whose mask is one bit too wide or too narrow, and such an error would either trap legal neighbours or let a privileged instruction run in user mode. It goes after the edges of the ranged groups: 0x46BF/0x4700, 0x4E5F/0x4E70, 0x4E79/0x4E7C, the 0x0EC0 hole in the address-space move group, and the words next to the three trap patterns. A design that ignored the mode bit would trap supervisor code. One that ignored decode_valid would report exceptions for bubbles. One whose output stage had the wrong latency would fail every cycle of the comparison.

// File: rtl/opc_exc_pkg.sv
package opc_exc_pkg;
   localparam int OPC_W = 16;

   typedef enum logic [2:0] {
      CLS_NONE    = 3'd0,
      CLS_LINE_A  = 3'd1,
      CLS_LINE_F  = 3'd2,
      CLS_TRAPPAT = 3'd3,
      CLS_PRIV    = 3'd4
   } exc_cls_e;
endpackage

// File: rtl/opc_line_detect.sv
module opc_line_detect
   import opc_exc_pkg::*;
#(
   parameter int          NIB_W    = 4,
   parameter logic [3:0]  LINE_A_N = 4'b1010,
   parameter logic [3:0]  LINE_F_N = 4'b1111
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             hit_a,
   output logic             hit_f
);
   localparam int TOP = OPC_W - 1;
   localparam int LOW = OPC_W - NIB_W;

   if (NIB_W != 4) begin : g_bad_nib
      $error("opc_line_detect: NIB_W must be 4");
   end
   if (LINE_A_N == LINE_F_N) begin : g_same_line
      $error("opc_line_detect: the two emulation lines must differ");
   end

   always_comb begin
      hit_a = (opcode[TOP:LOW] == LINE_A_N);
      hit_f = (opcode[TOP:LOW] == LINE_F_N);
   end
endmodule

// File: rtl/opc_trap_detect.sv
module opc_trap_detect
   import opc_exc_pkg::*;
#(
   parameter logic [15:0] TRAP_BASE = 16'h4AFA,
   parameter int          TRAP_CNT  = 3
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             hit
);
   if (TRAP_CNT < 1 || TRAP_CNT > 16) begin : g_bad_cnt
      $error("opc_trap_detect: TRAP_CNT out of range");
   end

   logic [TRAP_CNT-1:0] each;

   for (genvar i = 0; i < TRAP_CNT; i++) begin : g_pat
      localparam logic [15:0] PAT = TRAP_BASE + 16'(i);
      assign each[i] = (opcode == PAT);
   end

   assign hit = |each;
endmodule

// File: rtl/opc_priv_detect.sv
module opc_priv_detect
   import opc_exc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output logic             hit
);
   localparam int NPAT = 10;

   // match value / care mask pairs for privileged words
   localparam logic [15:0] P_VAL [NPAT] = '{
      16'h007C, 16'h027C, 16'h0A7C,
      16'h40C0, 16'h46C0, 16'h4E60,
      16'h4E70, 16'h4E72, 16'h4E73,
      16'h4E7A
   };
   localparam logic [15:0] P_MSK [NPAT] = '{
      16'hFFFF, 16'hFFFF, 16'hFFFF,
      16'hFFC0, 16'hFFC0, 16'hFFF0,
      16'hFFFF, 16'hFFFF, 16'hFFFF,
      16'hFFFE
   };

   logic [NPAT-1:0] each;
   logic            as_move;

   for (genvar i = 0; i < NPAT; i++) begin : g_pat
      assign each[i] = ((opcode & P_MSK[i]) == P_VAL[i]);
   end

   // address-space move: size field 11 is not part of that group
   assign as_move = (opcode[15:8] == 8'h0E) && (opcode[7:6] != 2'b11);

   assign hit = (|each) | as_move;
endmodule

// File: rtl/opc_vec_select.sv
module opc_vec_select
   import opc_exc_pkg::*;
#(
   parameter int                VEC_W     = 8,
   parameter logic [VEC_W-1:0]  VEC_TRAP  = 8'd4,
   parameter logic [VEC_W-1:0]  VEC_PRIV  = 8'd8,
   parameter logic [VEC_W-1:0]  VEC_LINEA = 8'd10,
   parameter logic [VEC_W-1:0]  VEC_LINEF = 8'd11
) (
   input  logic             qual,
   input  logic             supervisor,
   input  logic             line_a,
   input  logic             line_f,
   input  logic             trap,
   input  logic             priv,
   output exc_cls_e         cls,
   output logic             valid,
   output logic [VEC_W-1:0] vector
);
   always_comb begin
      cls = CLS_NONE;
      if (qual) begin
         if (line_a)                 cls = CLS_LINE_A;
         else if (line_f)            cls = CLS_LINE_F;
         else if (trap)              cls = CLS_TRAPPAT;
         else if (priv && !supervisor) cls = CLS_PRIV;
      end
   end

   always_comb begin
      unique case (cls)
         CLS_LINE_A:  vector = VEC_LINEA;
         CLS_LINE_F:  vector = VEC_LINEF;
         CLS_TRAPPAT: vector = VEC_TRAP;
         CLS_PRIV:    vector = VEC_PRIV;
         default:     vector = '0;
      endcase
      valid = (cls != CLS_NONE);
   end
endmodule

// File: rtl/opc_exc_classifier.sv
module opc_exc_classifier
   import opc_exc_pkg::*;
#(
   parameter int               VEC_W     = 8,
   parameter bit               OUT_REG   = 1'b1,
   parameter logic [VEC_W-1:0] VEC_TRAP  = 8'd4,
   parameter logic [VEC_W-1:0] VEC_PRIV  = 8'd8,
   parameter logic [VEC_W-1:0] VEC_LINEA = 8'd10,
   parameter logic [VEC_W-1:0] VEC_LINEF = 8'd11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             decode_valid,
   input  logic [15:0]      opcode,
   input  logic             supervisor,
   output logic             exc_valid,
   output logic [7:0]       exc_vector
);
   if (VEC_W != 8) begin : g_bad_vw
      $error("opc_exc_classifier: VEC_W must be 8");
   end
   if (OPC_W != 16) begin : g_bad_ow
      $error("opc_exc_classifier: OPC_W must be 16");
   end
   if (VEC_TRAP == VEC_PRIV || VEC_TRAP == VEC_LINEA || VEC_TRAP == VEC_LINEF ||
       VEC_PRIV == VEC_LINEA || VEC_PRIV == VEC_LINEF || VEC_LINEA == VEC_LINEF ||
       VEC_TRAP == '0 || VEC_PRIV == '0 || VEC_LINEA == '0 || VEC_LINEF == '0) begin : g_bad_vec
      $error("opc_exc_classifier: vectors must be distinct and nonzero");
   end

   logic             line_a, line_f, trap_hit, priv_hit;
   exc_cls_e         cls;
   logic             nxt_valid;
   logic [VEC_W-1:0] nxt_vector;

   opc_line_detect u_line (
      .opcode (opcode),
      .hit_a  (line_a),
      .hit_f  (line_f)
   );

   opc_trap_detect u_trap (
      .opcode (opcode),
      .hit    (trap_hit)
   );

   opc_priv_detect u_priv (
      .opcode (opcode),
      .hit    (priv_hit)
   );

   opc_vec_select #(
      .VEC_W     (VEC_W),
      .VEC_TRAP  (VEC_TRAP),
      .VEC_PRIV  (VEC_PRIV),
      .VEC_LINEA (VEC_LINEA),
      .VEC_LINEF (VEC_LINEF)
   ) u_sel (
      .qual       (decode_valid),
      .supervisor (supervisor),
      .line_a     (line_a),
      .line_f     (line_f),
      .trap       (trap_hit),
      .priv       (priv_hit),
      .cls        (cls),
      .valid      (nxt_valid),
      .vector     (nxt_vector)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            exc_valid  <= 1'b0;
            exc_vector <= '0;
         end else begin
            exc_valid  <= nxt_valid;
            exc_vector <= nxt_vector;
         end
      end

      // R7
      qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         exc_valid |-> $past(decode_valid));

      // R8
      reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         nxt_valid |=> exc_valid);
   end else begin : g_comb
      assign exc_valid  = nxt_valid;
      assign exc_vector = nxt_vector;
   end

   // R1
   trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_valid && trap_hit) |-> (nxt_vector == VEC_TRAP));

   // R2
   line_a_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_valid && line_a) |-> (nxt_vector == VEC_LINEA));

   // R3
   line_f_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_valid && line_f) |-> (nxt_vector == VEC_LINEF));

   // R5
   sup_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (supervisor && priv_hit) |-> !nxt_valid);

   // R9
   one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({line_a, line_f, trap_hit, priv_hit}));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nxt_valid |-> (nxt_vector == '0));
endmodule

// File: tb/tb_opc_exc_classifier.sv
module tb_opc_exc_classifier;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        decode_valid = 1'b0;
   logic [15:0] opcode = '0;
   logic        supervisor = 1'b0;
   logic        exc_valid;
   logic [7:0]  exc_vector;

   int errors = 0;
   int checks = 0;

   logic        have_prev = 1'b0;
   logic        prev_valid;
   logic [7:0]  prev_vec;
   string       prev_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   opc_exc_classifier dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .decode_valid (decode_valid),
      .opcode       (opcode),
      .supervisor   (supervisor),
      .exc_valid    (exc_valid),
      .exc_vector   (exc_vector)
   );

   function automatic bit is_priv(input logic [15:0] w);
      return (w == 16'h007C) || (w == 16'h027C) || (w == 16'h0A7C) ||
             (w >= 16'h40C0 && w <= 16'h40FF) ||
             (w >= 16'h46C0 && w <= 16'h46FF) ||
             (w >= 16'h4E60 && w <= 16'h4E6F) ||
             (w == 16'h4E70) || (w == 16'h4E72) || (w == 16'h4E73) ||
             (w == 16'h4E7A) || (w == 16'h4E7B) ||
             (w >= 16'h0E00 && w <= 16'h0EBF);
   endfunction

   // reference model: returns expected vector (0 = none) and requirement tag
   task automatic model(input logic v, input logic [15:0] w, input logic s,
                        output logic ev, output logic [7:0] vec, output string tag);
      ev = 1'b0; vec = 8'd0;
      if (!v)                                begin tag = "R7"; end
      else if (w[15:12] == 4'hA)             begin ev = 1; vec = 8'd10; tag = "R2"; end
      else if (w[15:12] == 4'hF)             begin ev = 1; vec = 8'd11; tag = "R3"; end
      else if (w >= 16'h4AFA && w <= 16'h4AFC) begin ev = 1; vec = 8'd4; tag = "R1"; end
      else if (is_priv(w) && !s)             begin ev = 1; vec = 8'd8; tag = "R4"; end
      else if (is_priv(w))                   begin tag = "R5"; end
      else                                   begin tag = "R6"; end
   endtask

   task automatic compare();
      if (have_prev) begin
         checks++;
         if (exc_valid !== prev_valid || exc_vector !== prev_vec) begin
            errors++;
            $display("FAIL %s: got valid=%0b vec=%0d, expected valid=%0b vec=%0d",
                     prev_tag, exc_valid, exc_vector, prev_valid, prev_vec);
         end
         // R9: a raised flag carries one of the four legal vectors
         if (exc_valid === 1'b1 && !(exc_vector inside {8'd4, 8'd8, 8'd10, 8'd11})) begin
            errors++;
            $display("FAIL R9: got vec=%0d, expected one of 4/8/10/11", exc_vector);
         end
      end
   endtask

   // drive one word; the result is checked one clock later (R8)
   task automatic apply(input logic v, input logic [15:0] w, input logic s);
      logic ev; logic [7:0] vec; string tag;
      @(negedge clk);
      compare();
      model(v, w, s, ev, vec, tag);
      decode_valid = v; opcode = w; supervisor = s;
      prev_valid = ev; prev_vec = vec; prev_tag = tag; have_prev = 1'b1;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      checks++;
      if (exc_valid !== 1'b0 || exc_vector !== 8'd0) begin
         errors++;
         $display("FAIL R8: got valid=%0b vec=%0d in reset, expected 0/0", exc_valid, exc_vector);
      end
      rst_n = 1'b1;

      // directed corners: R1 R2 R3 R4 R5 R6 R7
      apply(1, 16'h4AFA, 0); apply(1, 16'h4AFB, 1); apply(1, 16'h4AFC, 0);
      apply(1, 16'h4AF9, 0); apply(1, 16'h4AFD, 0);
      apply(1, 16'hA000, 1); apply(1, 16'hAFFF, 0);
      apply(1, 16'hF000, 0); apply(1, 16'hFFFF, 1);
      apply(1, 16'h46C0, 0); apply(1, 16'h46BF, 0); apply(1, 16'h4700, 0);
      apply(1, 16'h4E73, 1); apply(1, 16'h4E71, 0); apply(1, 16'h0EC0, 0);
      apply(0, 16'h4AFC, 0); apply(0, 16'hA123, 1); apply(0, 16'h027C, 0);
      // back-to-back alternation, checks each cycle's own result (R8)
      apply(1, 16'h027C, 0); apply(1, 16'h027C, 1); apply(1, 16'hF123, 0);

      // exhaustive sweep in both modes
      for (int m = 0; m < 2; m++) begin
         for (int w = 0; w < 65536; w++) begin
            apply(1'b1, 16'(w), 1'(m));
         end
      end
      apply(0, 16'h0000, 0);
      @(negedge clk);
      compare();
      have_prev = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule